// File: doc/BRIEF.md
# Block Move Sequencer

This block carries out a seven-byte block-move instruction once the opcode and its three 16-bit operands (source, destination, length) have been decoded elsewhere. After a one-cycle `start` with one of five recognised opcodes, it saves the A, X and Y registers on the page-1 stack. It then copies the requested number of bytes, one read and one write per element, and finally pops the saved registers back and presents them on its outputs. The opcode chooses how the source and destination addresses step after each element: both up, both down, source up with a fixed destination, source up with a destination that alternates between two neighbouring addresses, or an alternating source with a destination that counts up. The alternating form serves a two-byte data-port register.

The memory side is a single synchronous request port. A read returns its byte on `mem_rdata` in the cycle after the request. `busy` stays high for the whole instruction and is meant to mask interrupts. `done` pulses in the last busy cycle, when the restored register values on `a_out`, `x_out` and `y_out` are valid.

The controller is one enumerated state machine:

- IDLE: waits for a valid start.
- PUSH: three stack writes.
- PREP: eight overhead cycles.
- READ: source read.
- HOLD: four cycles.
- WRITE: destination write.
- POP: three stack reads.
- TAIL: three overhead cycles.

Its transitions:

- IDLE→PUSH on start with a known opcode.
- PUSH→PREP after the third push.
- PREP→READ after the eighth cycle.
- READ→HOLD always.
- HOLD→WRITE after the fourth cycle.
- WRITE→READ while elements remain.
- WRITE→POP after the last element.
- POP→TAIL after the third pop.
- TAIL→IDLE after the third cycle, with `done`.

Top module: `block_move_engine`

## Requirements
- R1: A start is accepted only in IDLE and only with opcode 0x73, 0xC3, 0xD3, 0xE3 or 0xF3. Any other opcode leaves `busy` low and issues no memory request.
- R2: The first three busy cycles write A, X and Y, in that order, to addresses 0x0100+SP, 0x0100+(SP−1) and 0x0100+(SP−2). The SP arithmetic wraps within 8 bits.
- R3: After the transfer, three reads come from 0x0100+(SP−2), (SP−1) and SP. They restore Y, X and A, and the restored values are on `a_out`, `x_out` and `y_out` when `done` pulses.
- R4: Element i is read from its source address and written, five cycles later, to its destination address with the byte read. Element i+1 starts only after element i has been written. Read data arrives one cycle after the request.
- R5: Opcode 0x73 uses source = S+i and destination = D+i.
- R6: Opcode 0xC3 uses source = S−i and destination = D−i.
- R7: Opcode 0xD3 uses source = S+i and the same destination D for every element.
- R8: Opcode 0xE3 uses destination D on even i and D+1 on odd i, with the source at S+i. Opcode 0xF3 uses source S on even i and S+1 on odd i, with the destination at D+i. The alternation restarts at the base for every new instruction.
- R9: A length of 0 moves 2^CNT_W elements. Any other length L moves L elements.
- R10: All address arithmetic, including base+1 in the alternating modes, wraps modulo 2^16.
- R11: `busy` is high for exactly 17 + 6·N cycles. `done` is high only in the last of them. A `start` while busy has no effect.
- R12: `mem_req` is high only while `busy` is high, and all outputs are idle in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in IDLE) |
| opcode | input | 8 | Decoded opcode selecting the stepping mode |
| src_base | input | AW (16) | Source start address |
| dst_base | input | AW (16) | Destination start address |
| length | input | CNT_W (16) | Element count, 0 meaning 2^CNT_W |
| a_in | input | DW (8) | A register value to save |
| x_in | input | DW (8) | X register value to save |
| y_in | input | DW (8) | Y register value to save |
| sp_in | input | 8 | Stack pointer at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (16) | Memory address |
| mem_wdata | output | DW (8) | Write data |
| mem_rdata | input | DW (8) | Read data, valid one cycle after a read request |
| busy | output | 1 | Instruction in progress; masks interrupts |
| done | output | 1 | One-cycle pulse in the last busy cycle |
| a_out | output | DW (8) | Restored A |
| x_out | output | DW (8) | Restored X |
| y_out | output | DW (8) | Restored Y |

## Verification
On every cycle, the assertions check the following local rules:
- how each address unit moves per step kind;
- that the alternation restarts on load;
- that a written byte is the one read four cycles earlier;
- that requests stay inside busy;
- that bad opcodes are refused;
- that `done` closes the busy window.

Only the bench scenarios can show the end-to-end properties:
- whole-memory results for each mode, including wraps at 0xFFFF/0x0000;
- the exact 17+6N cycle count;
- the 2^CNT_W case for a zero length;
- immunity to a start issued mid-transfer;
- correct pairing of pushes with pops.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

    typedef enum logic [1:0] {
        K_INC,
        K_DEC,
        K_FIX,
        K_ALT
    } step_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_PREP,
        S_READ,
        S_HOLD,
        S_WRITE,
        S_POP,
        S_TAIL
    } seq_state_t;

    localparam logic [7:0] OP_UP_UP    = 8'h73;
    localparam logic [7:0] OP_DN_DN    = 8'h C3;
    localparam logic [7:0] OP_UP_FIX   = 8'hD3;
    localparam logic [7:0] OP_UP_ALT   = 8'hE3;
    localparam logic [7:0] OP_ALT_UP   = 8'hF3;

    localparam int SP_W      = 8;
    localparam int SAVE_REGS = 3;
    localparam int PREP_CYC  = 8;
    localparam int HOLD_CYC  = 4;
    localparam int TAIL_CYC  = 3;
    localparam int ELEM_CYC  = HOLD_CYC + 2;
    localparam int OVERHEAD  = 2 * SAVE_REGS + PREP_CYC + TAIL_CYC;

endpackage

// File: rtl/bmt_decode.sv
module bmt_decode
    import bmt_pkg::*;
(
    input  logic [7:0]  opcode,
    output logic        valid,
    output step_kind_t  src_kind,
    output step_kind_t  dst_kind
);

    always_comb begin
        valid    = 1'b1;
        src_kind = K_INC;
        dst_kind = K_INC;
        case (opcode)
            OP_UP_UP:  begin src_kind = K_INC; dst_kind = K_INC; end
            OP_DN_DN:  begin src_kind = K_DEC; dst_kind = K_DEC; end
            OP_UP_FIX: begin src_kind = K_INC; dst_kind = K_FIX; end
            OP_UP_ALT: begin src_kind = K_INC; dst_kind = K_ALT; end
            OP_ALT_UP: begin src_kind = K_ALT; dst_kind = K_INC; end
            default:   valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/bmt_addr_unit.sv
module bmt_addr_unit
    import bmt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  step_kind_t    kind,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] ptr;
    logic          tog;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            tog <= 1'b0;
        end else if (load) begin
            ptr <= base;
            tog <= 1'b0;
        end else if (step) begin
            unique case (kind)
                K_INC: ptr <= ptr + AW'(1);
                K_DEC: ptr <= ptr - AW'(1);
                K_FIX: ptr <= ptr;
                K_ALT: tog <= ~tog;
            endcase
        end
    end

    assign addr = ptr + AW'(tog);

    // R5: an up-step moves the address by one
    assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && kind == K_INC) |=> addr == $past(addr) + AW'(1));

    // R6: a down-step moves the address back by one
    assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && kind == K_DEC) |=> addr == $past(addr) - AW'(1));

    // R7: a fixed address never moves
    assert_fix_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && kind == K_FIX) |=> $stable(addr));

    // R8: alternation goes base -> base+1 -> base
    assert_alt_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && kind == K_ALT && !tog) |=> addr == $past(addr) + AW'(1));
    assert_alt_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && kind == K_ALT && tog) |=> addr == $past(addr) - AW'(1));

    // R8: every load restarts at the base
    assert_load_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(base));

endmodule

// File: rtl/block_move_engine.sv
module block_move_engine
    import bmt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [CNT_W-1:0] length,
    input  logic [DW-1:0]    a_in,
    input  logic [DW-1:0]    x_in,
    input  logic [DW-1:0]    y_in,
    input  logic [7:0]       sp_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    a_out,
    output logic [DW-1:0]    x_out,
    output logic [DW-1:0]    y_out
);

    localparam int TMR_W = $clog2(PREP_CYC);
    localparam logic [AW-1:0] STACK_BASE = AW'(16'h0100);

    seq_state_t state, state_nx;
    logic [TMR_W-1:0] tmr, tmr_lim;
    logic             tmr_last;

    logic             dec_valid;
    step_kind_t       dec_src, dec_dst;
    step_kind_t       src_kind_q, dst_kind_q;
    logic             go;

    logic [CNT_W-1:0] cnt;
    logic             last_elem;
    logic [DW-1:0]    a_sv, x_sv, y_sv, data_q;
    logic [SP_W-1:0]  sp_sv, sp_push, sp_pop;
    logic             pop_vld;
    logic [1:0]       pop_sel;

    logic [1:0][AW-1:0] unit_base;
    step_kind_t [1:0]   unit_kind;
    logic [1:0][AW-1:0] unit_addr;
    logic               unit_step;

    bmt_decode u_decode (
        .opcode   (opcode),
        .valid    (dec_valid),
        .src_kind (dec_src),
        .dst_kind (dec_dst)
    );

    assign go = (state == S_IDLE) && start && dec_valid;

    // index 0 = source, index 1 = destination
    assign unit_base[0] = src_base;
    assign unit_base[1] = dst_base;
    assign unit_kind[0] = src_kind_q;
    assign unit_kind[1] = dst_kind_q;
    assign unit_step    = (state == S_WRITE);

    for (genvar g = 0; g < 2; g++) begin : g_addr
        bmt_addr_unit #(.AW(AW)) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (go),
            .base  (unit_base[g]),
            .step  (unit_step),
            .kind  (unit_kind[g]),
            .addr  (unit_addr[g])
        );
    end

    // per-state dwell length
    always_comb begin
        unique case (state)
            S_PUSH:  tmr_lim = TMR_W'(SAVE_REGS - 1);
            S_PREP:  tmr_lim = TMR_W'(PREP_CYC - 1);
            S_HOLD:  tmr_lim = TMR_W'(HOLD_CYC - 1);
            S_POP:   tmr_lim = TMR_W'(SAVE_REGS - 1);
            S_TAIL:  tmr_lim = TMR_W'(TAIL_CYC - 1);
            default: tmr_lim = '0;
        endcase
    end
    assign tmr_last  = (tmr == tmr_lim);
    assign last_elem = (cnt == CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (go)       state_nx = S_PUSH;
            S_PUSH:  if (tmr_last) state_nx = S_PREP;
            S_PREP:  if (tmr_last) state_nx = S_READ;
            S_READ:                state_nx = S_HOLD;
            S_HOLD:  if (tmr_last) state_nx = S_WRITE;
            S_WRITE:               state_nx = last_elem ? S_POP : S_READ;
            S_POP:   if (tmr_last) state_nx = S_TAIL;
            S_TAIL:  if (tmr_last) state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr        <= '0;
            cnt        <= '0;
            a_sv       <= '0;
            x_sv       <= '0;
            y_sv       <= '0;
            sp_sv      <= '0;
            data_q     <= '0;
            src_kind_q <= K_INC;
            dst_kind_q <= K_INC;
            pop_vld    <= 1'b0;
            pop_sel    <= '0;
            a_out      <= '0;
            x_out      <= '0;
            y_out      <= '0;
        end else begin
            tmr <= (state_nx != state) ? '0 : tmr + TMR_W'(1);
            if (go) begin
                cnt        <= length;
                a_sv       <= a_in;
                x_sv       <= x_in;
                y_sv       <= y_in;
                sp_sv      <= sp_in;
                src_kind_q <= dec_src;
                dst_kind_q <= dec_dst;
            end
            if (state == S_WRITE) cnt <= cnt - CNT_W'(1);
            if (state == S_HOLD && tmr == '0) data_q <= mem_rdata;
            pop_vld <= (state == S_POP);
            pop_sel <= tmr[1:0];
            if (pop_vld) begin
                case (pop_sel)
                    2'd0:    y_out <= mem_rdata;
                    2'd1:    x_out <= mem_rdata;
                    default: a_out <= mem_rdata;
                endcase
            end
        end
    end

    assign sp_push = sp_sv - SP_W'(tmr);
    assign sp_pop  = sp_sv - SP_W'(SAVE_REGS - 1) + SP_W'(tmr);

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = (state != S_IDLE);
        done      = (state == S_TAIL) && tmr_last;
        unique case (state)
            S_PUSH: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = STACK_BASE | AW'(sp_push);
                case (tmr)
                    TMR_W'(0): mem_wdata = a_sv;
                    TMR_W'(1): mem_wdata = x_sv;
                    default:   mem_wdata = y_sv;
                endcase
            end
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = unit_addr[0];
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = unit_addr[1];
                mem_wdata = data_q;
            end
            S_POP: begin
                mem_req  = 1'b1;
                mem_addr = STACK_BASE | AW'(sp_pop);
            end
            default: ;
        endcase
    end

    // R1: unknown opcodes are refused
    assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !dec_valid) |=> !busy);

    // R2: the first busy cycle pushes A
    assert_first_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && mem_we && mem_wdata == a_sv));

    // R4: the byte written is the byte returned after the read
    assert_write_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> mem_wdata == $past(mem_rdata, HOLD_CYC));

    // R11: done lies inside busy and closes it; busy never drops early
    assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R12: requests only while busy
    assert_req_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: tb/block_move_engine_tb.sv
`timescale 1ns/1ps
module block_move_engine_tb;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [15:0]   src_base = '0, dst_base = '0;
    logic [CW-1:0] length = '0;
    logic [7:0]    a_in = '0, x_in = '0, y_in = '0, sp_in = '0;
    logic          mem_req, mem_we, busy, done;
    logic [15:0]   mem_addr;
    logic [7:0]    mem_wdata, mem_rdata, a_out, x_out, y_out;

    logic [7:0] mem  [0:4095];
    logic [7:0] refm [0:4095];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    block_move_engine #(.AW(16), .DW(8), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_base(src_base), .dst_base(dst_base), .length(length),
        .a_in(a_in), .x_in(x_in), .y_in(y_in), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done),
        .a_out(a_out), .x_out(x_out), .y_out(y_out)
    );

    // registered memory, 12-bit image of the 16-bit space
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // 0 up, 1 down, 2 fixed, 3 alternate
    function automatic logic [15:0] ea(input int k, input logic [15:0] b, input int i);
        case (k)
            0:       return b + 16'(i);
            1:       return b - 16'(i);
            2:       return b;
            default: return b + 16'(i % 2);
        endcase
    endfunction

    function automatic int skind(input logic [7:0] op);
        case (op)
            8'hC3:   return 1;
            8'hF3:   return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int dkind(input logic [7:0] op);
        case (op)
            8'hC3:   return 1;
            8'hD3:   return 2;
            8'hE3:   return 3;
            default: return 0;
        endcase
    endfunction

    task automatic run_move(input logic [7:0] op, input logic [15:0] s, input logic [15:0] d,
                            input int n, input logic [7:0] a, input logic [7:0] x,
                            input logic [7:0] y, input logic [7:0] sp,
                            input bit poke, input string req);
        int cyc = 0;
        int dones = 0;
        int bad = 0;
        int first_bad = -1;
        // reference: pushes then sequential copies
        refm[{4'h1, sp}]          = a;
        refm[{4'h1, 8'(sp - 1)}]  = x;
        refm[{4'h1, 8'(sp - 2)}]  = y;
        for (int i = 0; i < n; i++) begin
            logic [15:0] sa, da;
            sa = ea(skind(op), s, i);
            da = ea(dkind(op), d, i);
            refm[da[11:0]] = refm[sa[11:0]];
        end
        @(negedge clk);
        opcode = op; src_base = s; dst_base = d; length = CW'(n);
        a_in = a; x_in = x; y_in = y; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && cyc < 4000) begin
            cyc++;
            if (done) dones++;
            if (poke && cyc == 10) begin
                start = 1'b1; opcode = 8'h73; src_base = 16'h0E00; dst_base = 16'h0E80;
                length = CW'(3); a_in = 8'h00;
            end else if (poke && cyc == 11) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        if (cyc >= 4000) chk(1'b0, "R11", "watchdog busy cycles", cyc, 17 + 6 * n);
        chk(cyc == 17 + 6 * n, "R11", {req, " busy length"}, cyc, 17 + 6 * n);
        chk(dones == 1, "R11", {req, " done pulses"}, dones, 1);
        chk({a_out, x_out, y_out} == {a, x, y}, "R3", {req, " restored AXY"},
            int'({a_out, x_out, y_out}), int'({a, x, y}));
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== refm[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        chk(bad == 0, req, "memory image mismatches", bad, 0);
        if (bad != 0)
            $display("  first mismatch at 0x%0h: actual 0x%0h expected 0x%0h",
                     first_bad, mem[first_bad], refm[first_bad]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'((i * 37 + 11) ^ (i >> 4));
            refm[i] = 8'((i * 37 + 11) ^ (i >> 4));
        end
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done, "R12", "reset outputs",
            int'({busy, mem_req, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: unknown opcode refused
        begin
            int seen = 0;
            opcode = 8'h74; src_base = 16'h0200; dst_base = 16'h0300; length = CW'(4);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (busy || mem_req) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R1", "busy/req after bad opcode", seen, 0);
        end

        run_move(8'h73, 16'h0200, 16'h0300, 5, 8'hA1, 8'hB2, 8'hC3, 8'hFF, 0, "R5");
        run_move(8'hC3, 16'h0410, 16'h0520, 7, 8'h11, 8'h22, 8'h33, 8'hF0, 0, "R6");
        run_move(8'hD3, 16'h0240, 16'h0600, 6, 8'h44, 8'h55, 8'h66, 8'h80, 0, "R7");
        run_move(8'hE3, 16'h0260, 16'h0700, 5, 8'h77, 8'h88, 8'h99, 8'h7F, 0, "R8");
        // R8: alternation restarts after an odd-length run
        run_move(8'hE3, 16'h0280, 16'h0700, 2, 8'h5A, 8'hA5, 8'h3C, 8'h7F, 0, "R8");
        run_move(8'hF3, 16'h0800, 16'h0900, 6, 8'h01, 8'h02, 8'h03, 8'h01, 0, "R8");
        // R2: push placement with 8-bit SP wrap (SP=1 -> 0x101, 0x100, 0x1FF)
        chk(mem[12'h101] == 8'h01 && mem[12'h100] == 8'h02 && mem[12'h1FF] == 8'h03,
            "R2", "stack bytes A,X,Y",
            int'({mem[12'h101], mem[12'h100], mem[12'h1FF]}), 24'h010203);
        // R10: wraps
        run_move(8'h73, 16'hFFFD, 16'h0A00, 6, 8'h12, 8'h34, 8'h56, 8'hC0, 0, "R10");
        run_move(8'hC3, 16'h0B10, 16'h0002, 5, 8'h65, 8'h43, 8'h21, 8'hC0, 0, "R10");
        run_move(8'hE3, 16'h0C80, 16'hFFFF, 4, 8'hDE, 8'hAD, 8'hBE, 8'hC8, 0, "R10");
        // R4: single element
        run_move(8'h73, 16'h0250, 16'h0350, 1, 8'h0F, 8'hF0, 8'h5A, 8'hD0, 0, "R4");
        // R9: zero length means 2^CNT_W
        run_move(8'h73, 16'h0C00, 16'h0D00, 256, 8'h9A, 8'hBC, 8'hDE, 8'hE0, 0, "R9");
        // R11: start during busy ignored
        run_move(8'hD3, 16'h0380, 16'h0610, 4, 8'h13, 8'h57, 8'h9B, 8'hA0, 1, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule